// File: doc/BRIEF.md
# YCrCb 4:2:2 Encoder-Port Formatter

This block sits between a colour-space stage that already delivers one luma sample and one pair of colour-difference samples per pixel, and the pixel port of a television video encoder. It places those samples on one of two bus layouts:

- **Wide layout:** Y, Cr and Cb each have their own lane.
- **Narrow layout:** Y keeps its lane, and Cr and Cb take turns on a single shared lane. The otherwise idle Cb lane then carries, on its least significant bit, a marker that says which colour difference the shared lane holds.

The block runs from the encoder clock and derives a data strobe at half that rate. Every output changes only on that strobe. The half-rate strobe is also brought out, so the encoder can latch the data.

A line-valid input marks active pixels. While it is low, the lanes carry fixed black and neutral-chroma levels. The first active pixel of each line always carries the colour difference chosen by the order input. Every following active pixel takes the other one.

Top module: `ycc422_out_fmt`

## Requirements
- R1: `dclk_half` alternates between 0 and 1 on every `clk` rising edge after reset. It is 1 exactly in the clock cycle that follows an update edge. Outputs never change while it stays 0.
- R2: The input samples and control inputs present at an update edge (the edge at which `dclk_half` goes from 0 to 1) appear on `out_y`, `out_cr` and `out_cb` directly after that edge. They stay there for two `clk` cycles.
- R3: Wide layout (`mode_16` = 0) with `in_active` = 1 gives `out_y` = `in_y`, `out_cr` = `in_cr` and `out_cb` = `in_cb`.
- R4: With `in_active` = 0:
  - `out_y` = 16 and `out_cr` = 128.
  - `out_cb` = 128 in the wide layout and 0 in the narrow layout.
- R5: Narrow layout (`mode_16` = 1) with `in_active` = 1 gives the following:
  - `out_y` = `in_y`.
  - `out_cb[0]` is the marker: 1 means Cr and 0 means Cb.
  - `out_cr` = `in_cr` when the marker is 1 and `in_cb` when it is 0.
  - `out_cb[7:1]` = 0.
- R6: The first active sample after an inactive sample, or after reset, selects Cr when `cr_first` = 1 and Cb when `cr_first` = 0.
- R7: Each further active sample of the same line selects the opposite component from the previous one. This alternation keeps running when `mode_16` changes in mid-line.
- R8: While `rst_n` is low, `out_y` = 16, `out_cr` = 128, `out_cb` = 128 and `dclk_half` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_16 | input | 1 | 1 selects the narrow layout with a shared chroma lane |
| cr_first | input | 1 | 1 starts each line with Cr, 0 with Cb |
| in_active | input | 1 | Current sample lies in the active part of the line |
| in_y | input | 8 | Luma sample |
| in_cr | input | 8 | Red colour-difference sample |
| in_cb | input | 8 | Blue colour-difference sample |
| dclk_half | output | 1 | Half-rate data strobe, high in the cycle after each update |
| out_y | output | 8 | Luma lane |
| out_cr | output | 8 | Cr lane, or the shared chroma lane in the narrow layout |
| out_cb | output | 8 | Cb lane, or the Cr marker on bit 0 in the narrow layout |

## Verification
Corrupted alternation state shows up in the narrow layout as a wrong marker bit and a wrong sample on the shared lane. This appears on the very first update after the fault, or at the next line start if the line-start detector is the part at fault. Because every line start re-seeds the phase, a phase error never lasts beyond the end of the current line. The bench therefore uses short lines, single-pixel lines and mid-line layout changes to bring each kind of slip to the ports within a few strobes. A divider fault shows up within two encoder clocks, as a strobe that does not alternate or as lanes that move between strobes.

// File: rtl/ycc_fmt_pkg.sv
package ycc_fmt_pkg;

  // Default sample width of every lane.
  localparam int unsigned LANE_W_DEF = 8;

  // Which colour difference occupies the shared lane.
  typedef enum logic {
    CH_CB = 1'b0,
    CH_CR = 1'b1
  } chroma_sel_e;

  // Black luma level scaled to the lane width.
  function automatic int unsigned blank_luma(input int unsigned w);
    return 16 << (w - 8);
  endfunction

  // Neutral chroma level (mid-scale) for the lane width.
  function automatic int unsigned blank_chroma(input int unsigned w);
    return 1 << (w - 1);
  endfunction

endpackage

// File: rtl/ycc_rate_div.sv
// Divides the encoder clock by two and gives one update enable per pair
// of clocks, plus the registered half-rate strobe seen at the port.
module ycc_rate_div (
  input  logic clk,
  input  logic rst_n,
  output logic upd_en,
  output logic strobe
);

  logic ph_q, ph_d;
  logic stb_q, stb_d;

  always_comb begin
    ph_d  = ~ph_q;
    stb_d = ph_q;
  end

  // The phase starts at 1, so the first edge after reset is an update edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b1;
      stb_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      stb_q <= stb_d;
    end
  end

  assign upd_en = ph_q;
  assign strobe = stb_q;

endmodule

// File: rtl/ycc_chroma_phase.sv
// Tracks the Cr/Cb alternation and restarts it at every line start.
module ycc_chroma_phase
  import ycc_fmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd_en,
  input  logic        active,
  input  logic        cr_first,
  output chroma_sel_e cur_sel
);

  logic        prev_act_q, prev_act_d;
  chroma_sel_e last_sel_q, last_sel_d;
  logic        line_start;

  always_comb begin
    line_start = active & ~prev_act_q;
    if (line_start) begin
      cur_sel = cr_first ? CH_CR : CH_CB;
    end else begin
      cur_sel = (last_sel_q == CH_CR) ? CH_CB : CH_CR;
    end
  end

  always_comb begin
    prev_act_d = prev_act_q;
    last_sel_d = last_sel_q;
    if (upd_en) begin
      prev_act_d = active;
      if (active) begin
        last_sel_d = cur_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_act_q <= 1'b0;
      last_sel_q <= CH_CB;
    end else begin
      prev_act_q <= prev_act_d;
      last_sel_q <= last_sel_d;
    end
  end

endmodule

// File: rtl/ycc_lane_mux.sv
// Builds the next value of every lane from the samples, the layout and
// the current chroma selection.
module ycc_lane_mux
  import ycc_fmt_pkg::*;
#(
  parameter int unsigned DW = LANE_W_DEF
) (
  input  logic          active,
  input  logic          narrow,
  input  chroma_sel_e   sel,
  input  logic [DW-1:0] y_in,
  input  logic [DW-1:0] cr_in,
  input  logic [DW-1:0] cb_in,
  output logic [DW-1:0] y_nx,
  output logic [DW-1:0] cr_nx,
  output logic [DW-1:0] cb_nx
);

  localparam logic [DW-1:0] BLK_Y = DW'(blank_luma(DW));
  localparam logic [DW-1:0] BLK_C = DW'(blank_chroma(DW));

  logic [DW-1:0] marker_word;

  always_comb begin
    marker_word    = '0;
    marker_word[0] = (sel == CH_CR);
  end

  always_comb begin
    if (!active) begin
      y_nx  = BLK_Y;
      cr_nx = BLK_C;
      cb_nx = narrow ? '0 : BLK_C;
    end else if (!narrow) begin
      y_nx  = y_in;
      cr_nx = cr_in;
      cb_nx = cb_in;
    end else begin
      y_nx  = y_in;
      cr_nx = (sel == CH_CR) ? cr_in : cb_in;
      cb_nx = marker_word;
    end
  end

endmodule

// File: rtl/ycc422_out_fmt.sv
// Encoder-port formatter: wide or narrow 4:2:2 layout on a half-rate strobe.
module ycc422_out_fmt
  import ycc_fmt_pkg::*;
#(
  parameter int unsigned DW = LANE_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_16,
  input  logic          cr_first,
  input  logic          in_active,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_cr,
  input  logic [DW-1:0] in_cb,
  output logic          dclk_half,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_cr,
  output logic [DW-1:0] out_cb
);

  localparam logic [DW-1:0] RST_Y = DW'(blank_luma(DW));
  localparam logic [DW-1:0] RST_C = DW'(blank_chroma(DW));

  logic          upd_en;
  chroma_sel_e   cur_sel;
  logic [DW-1:0] y_nx, cr_nx, cb_nx;

  logic [DW-1:0] y_q, cr_q, cb_q;
  logic [DW-1:0] y_d, cr_d, cb_d;
  logic          mode_q, mode_d;
  logic          act_q, act_d;

  ycc_rate_div u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (upd_en),
    .strobe (dclk_half)
  );

  ycc_chroma_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (upd_en),
    .active   (in_active),
    .cr_first (cr_first),
    .cur_sel  (cur_sel)
  );

  ycc_lane_mux #(.DW(DW)) u_mux (
    .active (in_active),
    .narrow (mode_16),
    .sel    (cur_sel),
    .y_in   (in_y),
    .cr_in  (in_cr),
    .cb_in  (in_cb),
    .y_nx   (y_nx),
    .cr_nx  (cr_nx),
    .cb_nx  (cb_nx)
  );

  // Next state: load only on the update enable.
  always_comb begin
    y_d    = y_q;
    cr_d   = cr_q;
    cb_d   = cb_q;
    mode_d = mode_q;
    act_d  = act_q;
    if (upd_en) begin
      y_d    = y_nx;
      cr_d   = cr_nx;
      cb_d   = cb_nx;
      mode_d = mode_16;
      act_d  = in_active;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q    <= RST_Y;
      cr_q   <= RST_C;
      cb_q   <= RST_C;
      mode_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      y_q    <= y_d;
      cr_q   <= cr_d;
      cb_q   <= cb_d;
      mode_q <= mode_d;
      act_q  <= act_d;
    end
  end

  assign out_y  = y_q;
  assign out_cr = cr_q;
  assign out_cb = cb_q;

endmodule

// File: rtl/ycc_fmt_chk.sv
module ycc_fmt_chk
  import ycc_fmt_pkg::*;
#(
  parameter int unsigned DW = LANE_W_DEF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dclk_half,
  input logic          mode_q,
  input logic          act_q,
  input logic [DW-1:0] out_y,
  input logic [DW-1:0] out_cr,
  input logic [DW-1:0] out_cb
);

  localparam logic [DW-1:0] BLK_Y = DW'(blank_luma(DW));
  localparam logic [DW-1:0] BLK_C = DW'(blank_chroma(DW));

  a_r1_strobe_falls: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_half |=> !dclk_half);

  a_r1_strobe_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !dclk_half |=> dclk_half);

  a_r1_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !dclk_half |-> ($stable(out_y) && $stable(out_cr) && $stable(out_cb)));

  a_r4_blank_levels: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> (out_y == BLK_Y && out_cr == BLK_C));

  a_r5_marker_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (out_cb[DW-1:1] == '0));

  a_r7_marker_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_half && mode_q && act_q && $past(mode_q, 2) && $past(act_q, 2))
      |-> (out_cb[0] != $past(out_cb[0], 2)));

endmodule

bind ycc422_out_fmt ycc_fmt_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dclk_half (dclk_half),
  .mode_q    (mode_q),
  .act_q     (act_q),
  .out_y     (out_y),
  .out_cr    (out_cr),
  .out_cb    (out_cb)
);

// File: tb/sim_ycc422_out_fmt.sv
module sim_ycc422_out_fmt;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_16, cr_first, in_active;
  logic [7:0] in_y, in_cr, in_cb;
  logic       dclk_half;
  logic [7:0] out_y, out_cr, out_cb;

  always #4 clk = ~clk;

  ycc422_out_fmt u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_16   (mode_16),
    .cr_first  (cr_first),
    .in_active (in_active),
    .in_y      (in_y),
    .in_cr     (in_cr),
    .in_cb     (in_cb),
    .dclk_half (dclk_half),
    .out_y     (out_y),
    .out_cr    (out_cr),
    .out_cb    (out_cb)
  );

  logic [23:0] exp_q[$];
  string       tag_q[$];
  int          n_vec = 0;
  int          n_bad = 0;
  bit          mon_on = 1'b0;
  bit          done = 1'b0;
  logic [23:0] last_out;

  // Reference state derived from R6/R7.
  bit m_prev_act = 1'b0;
  bit m_last_cr  = 1'b0;

  task automatic apply(input logic act, input logic m16, input logic crf,
                       input logic [7:0] y, input logic [7:0] cr,
                       input logic [7:0] cb, input string tag);
    logic [23:0] e;
    bit ls, iscr;
    @(negedge clk);
    while (dclk_half !== 1'b1) @(negedge clk);
    ls   = act && !m_prev_act;
    iscr = ls ? crf : !m_last_cr;
    if (!act)      e = {8'd16, 8'd128, (m16 ? 8'd0 : 8'd128)};
    else if (!m16) e = {y, cr, cb};
    else           e = {y, (iscr ? cr : cb), {7'd0, iscr}};
    m_prev_act = act;
    if (act) m_last_cr = iscr;
    in_active = act; mode_16 = m16; cr_first = crf;
    in_y = y; in_cr = cr; in_cb = cb;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: sample 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (mon_on && !done) begin
      if (dclk_half === 1'b1) begin
        last_out = {out_y, out_cr, out_cb};
        if (exp_q.size() > 0) begin
          logic [23:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          n_vec++;
          if ({out_y, out_cr, out_cb} !== e) begin
            n_bad++;
            $display("FAIL %s: actual y=%0d cr=%0d cb=%0d expected y=%0d cr=%0d cb=%0d",
                     t, out_y, out_cr, out_cb, e[23:16], e[15:8], e[7:0]);
          end
        end
      end else begin
        n_vec++;
        if ({out_y, out_cr, out_cb} !== last_out) begin
          n_bad++;
          $display("FAIL R1: lanes moved without strobe actual=%h expected=%h",
                   {out_y, out_cr, out_cb}, last_out);
        end
      end
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R1: watchdog actual=timeout expected=completion");
    done = 1'b1;
    finish_run();
  end

  initial begin
    logic [23:0] lfsr;
    rst_n = 1'b0; in_active = 1'b0; mode_16 = 1'b0; cr_first = 1'b0;
    in_y = 8'd0; in_cr = 8'd0; in_cb = 8'd0;
    repeat (3) @(negedge clk);
    // R8: reset levels
    n_vec++;
    if ({dclk_half, out_y, out_cr, out_cb} !== {1'b0, 8'd16, 8'd128, 8'd128}) begin
      n_bad++;
      $display("FAIL R8: actual s=%0d y=%0d cr=%0d cb=%0d expected s=0 y=16 cr=128 cb=128",
               dclk_half, out_y, out_cr, out_cb);
    end
    last_out = {8'd16, 8'd128, 8'd128};
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R3: wide layout line
    for (int i = 0; i < 6; i++)
      apply(1'b1, 1'b0, 1'b1, 8'(i * 17 + 3), 8'(200 - i * 9), 8'(i * 31 + 1), "R3");
    apply(1'b0, 1'b0, 1'b1, 8'hAA, 8'h55, 8'h77, "R4");
    apply(1'b0, 1'b0, 1'b1, 8'h01, 8'h02, 8'h03, "R4");

    // R5/R6/R7: narrow layout, Cr first
    for (int i = 0; i < 7; i++)
      apply(1'b1, 1'b1, 1'b1, 8'(i * 11 + 40), 8'(i + 100), 8'(i + 60), (i == 0) ? "R6" : "R5");
    apply(1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF, "R4");
    apply(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, "R4");

    // R6: narrow layout, Cb first
    for (int i = 0; i < 5; i++)
      apply(1'b1, 1'b1, 1'b0, 8'(i * 7 + 90), 8'(i + 150), 8'(i + 20), (i == 0) ? "R6" : "R7");
    apply(1'b0, 1'b1, 1'b0, 8'h10, 8'h20, 8'h30, "R4");

    // R6: single-pixel lines restart the phase each time
    apply(1'b1, 1'b1, 1'b1, 8'd77, 8'd201, 8'd33, "R6");
    apply(1'b0, 1'b1, 1'b1, 8'd0,  8'd0,   8'd0,  "R4");
    apply(1'b1, 1'b1, 1'b1, 8'd78, 8'd202, 8'd34, "R6");
    apply(1'b0, 1'b1, 1'b0, 8'd0,  8'd0,   8'd0,  "R4");
    apply(1'b1, 1'b1, 1'b0, 8'd79, 8'd203, 8'd35, "R6");
    apply(1'b0, 1'b0, 1'b0, 8'd0,  8'd0,   8'd0,  "R4");

    // R7: layout change in mid-line keeps the alternation
    for (int i = 0; i < 8; i++)
      apply(1'b1, (i >= 3), 1'b1, 8'(i + 5), 8'(i + 170), 8'(i + 70), "R7");
    apply(1'b0, 1'b1, 1'b1, 8'd0, 8'd0, 8'd0, "R4");

    // R2: mixed pattern across all inputs
    lfsr = 24'hACE135;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      apply((lfsr[3:0] != 4'd0), lfsr[9], lfsr[14], lfsr[23:16], lfsr[15:8],
            lfsr[7:0] ^ lfsr[19:12], "R2");
    end
    apply(1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 8'd0, "R4");
    repeat (6) @(negedge clk);
    n_vec++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: pending outputs actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end

endmodule